// File: doc/BRIEF.md
# Two-Wire Serial Control Slave for a Dual 10-Bit DAC

This block is the serial front end of a two-channel, 10-bit digital-to-analog converter. It watches a two-wire bus (a clock line and an open-drain data line), oversampling both lines with a faster system clock. It recognizes bus start and stop conditions and checks the device address one bit at a time as each bit arrives. It acknowledges the address and every data byte by pulling the data line low. It then assembles a two-byte command/data word and loads it into the DAC code registers.

The 7-bit device address is made of a 6-bit prefix, set by a parameter, and a low bit taken from a strap pin. Up to four devices can therefore share one bus. The first data byte holds a 4-bit command in its upper nibble and the top four data bits in its lower nibble. The second byte holds the remaining six data bits and two trailing sub-bits, which must be zero. A word takes effect only at the falling clock edge that closes the acknowledge slot of its second byte. A transfer that is cut short leaves every register as it was.

In read mode the block releases the data line for every data bit. It reads the master's acknowledge and drops off the bus when the master does not acknowledge.

Top module: `i2c_dac_slave`

## Requirements
- R1: After reset both DAC codes are 0, the command output is 0000, the extended flag is 0, and the data line is released (`sda_hold_n` = 1).
- R2: An address byte whose upper seven bits equal {ADDR_PREFIX, addr_lsb_strap} is acknowledged: SDA is held low while SCL is high in the ninth clock. The byte's LSB is the transfer direction (0 = write, 1 = read).
- R3: On the first address bit that differs from the device address, the slave gives no acknowledge for that byte or for any later byte until a new START, and no register changes.
- R4: In write mode each of the two data bytes is acknowledged in its ninth clock.
- R5: Byte one is {C3..C0, D9..D6} and byte two is {D5..D0, S1, S0}. Command 0000 loads D9..D0 into channel A, 0001 into channel B, and 0010 into both. The committed command appears on `cmd_code`.
- R6: The DAC codes do not change during the eight data bits of the second byte or while SCL is high in its acknowledge clock. They take the new value only after the SCL falling edge that ends that acknowledge clock.
- R7: A STOP after the first data byte, or a repeated START inside the second data byte, discards the word and leaves all outputs unchanged.
- R8: Command 1111 with D9..D6 = 0000 sets `ext_cmd_flag` = 1 and leaves both DAC codes unchanged. Any other committed word clears the flag. Command 1111 with nonzero D9..D6 loads no channel.
- R9: A word whose sub-bits S1,S0 are not 00 is acknowledged but not committed.
- R10: In read mode the slave acknowledges the address, leaves SDA released for all eight data bits (the master reads 0xFF), and returns to idle when the master does not acknowledge. A byte clocked afterwards without a START is not acknowledged.
- R11: The slave drives SDA low only inside an acknowledge slot. It starts driving just after an SCL falling edge and releases just after the next one, or at once on START or STOP.
- R12: Several two-byte words may follow a single write address before STOP. Each word commits at its own final acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_lsb_strap | input | 1 | Device address bit 0 |
| scl_in | input | 1 | Bus clock line |
| sda_in | input | 1 | Bus data line, as seen on the wire |
| sda_hold_n | output | 1 | Open-drain drive enable; 0 pulls SDA low |
| dac_a_code | output | 10 | Channel A DAC code |
| dac_b_code | output | 10 | Channel B DAC code |
| cmd_code | output | 4 | Last committed command |
| ext_cmd_flag | output | 1 | Extended-command mode selected |

## Verification
A wrong state in the bus sequencer shows at the ports within a single bus clock. An acknowledge appears in the wrong slot or goes missing, which is visible on `sda_hold_n` at the next ninth clock. A corrupted shift register or byte count shows as wrong DAC codes or a wrong command. These become visible a couple of system cycles after the final acknowledge's falling edge, or as a change at a time when nothing should change. The bench therefore samples the DAC codes both before and after that edge, and checks them after each aborted transfer.

// File: rtl/i2c_dac_pkg.sv
package i2c_dac_pkg;
  localparam int DAC_W  = 10;
  localparam int CMD_W  = 4;
  localparam int NUM_CH = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } slv_state_e;

  localparam logic [CMD_W-1:0] CMD_LOAD_AB = 4'h2;
  localparam logic [CMD_W-1:0] CMD_EXT     = 4'hF;

  typedef struct packed {
    logic [CMD_W-1:0] cmd;
    logic [DAC_W-1:0] data;
  } dac_word_t;
endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_bus_sync.sv
module i2c_bus_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] scl_pipe_q, sda_pipe_q;
  logic scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe_q <= '1;
      sda_pipe_q <= '1;
    end else begin
      scl_pipe_q <= {scl_pipe_q[PW-2:0], scl_in};
      sda_pipe_q <= {sda_pipe_q[PW-2:0], sda_in};
    end
  end

  assign scl_now = scl_pipe_q[SYNC_STAGES-1];
  assign scl_old = scl_pipe_q[SYNC_STAGES];
  assign sda_now = sda_pipe_q[SYNC_STAGES-1];
  assign sda_old = sda_pipe_q[SYNC_STAGES];

  assign sda_s     = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_det = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_det  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c_dac_fsm.sv
module i2c_dac_fsm
  import i2c_dac_pkg::*;
#(
  parameter logic [5:0] ADDR_PREFIX = 6'b011100
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        addr_lsb,
  input  logic        sda_s,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_det,
  input  logic        stop_det,
  output slv_state_e  state_o,
  output logic        sda_hold_n,
  output logic        commit_o,
  output dac_word_t   word_o
);
  slv_state_e state_q, state_d;
  logic [3:0] bit_q, bit_d;
  logic [7:0] shift_q, shift_d, first_q, first_d;
  logic       byte_q, byte_d, rw_q, rw_d, commit_q, commit_d;
  dac_word_t  word_q, word_d;
  logic [6:0] own_addr;

  assign own_addr = {ADDR_PREFIX, addr_lsb};

  always_comb begin
    state_d  = state_q;
    bit_d    = bit_q;
    shift_d  = shift_q;
    first_d  = first_q;
    byte_d   = byte_q;
    rw_d     = rw_q;
    commit_d = 1'b0;
    word_d   = word_q;
    if (start_det) begin
      state_d = ST_ADDR;
      bit_d   = 4'd0;
      byte_d  = 1'b0;
    end else if (stop_det) begin
      state_d = ST_IDLE;
    end else begin
      case (state_q)
        ST_ADDR: begin
          if (scl_rise) begin
            if (bit_q < 4'd7 && sda_s != own_addr[3'd6 - bit_q[2:0]]) begin
              state_d = ST_IDLE;
            end else begin
              if (bit_q == 4'd7) rw_d = sda_s;
              bit_d = bit_q + 4'd1;
            end
          end else if (scl_fall && bit_q == 4'd8) begin
            state_d = ST_ADDR_ACK;
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_d   = 4'd0;
            byte_d  = 1'b0;
            state_d = rw_q ? ST_RD : ST_WR;
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            shift_d = {shift_q[6:0], sda_s};
            bit_d   = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            state_d = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            bit_d   = 4'd0;
            state_d = ST_WR;
            if (!byte_q) begin
              first_d = shift_q;
              byte_d  = 1'b1;
            end else begin
              byte_d   = 1'b0;
              commit_d = (shift_q[1:0] == 2'b00);
              word_d   = '{cmd: first_q[7:4], data: {first_q[3:0], shift_q[7:2]}};
            end
          end
        end
        ST_RD: begin
          if (scl_rise) bit_d = bit_q + 4'd1;
          else if (scl_fall && bit_q == 4'd8) state_d = ST_RD_ACK;
        end
        ST_RD_ACK: begin
          if (scl_rise && sda_s) begin
            state_d = ST_IDLE;
          end else if (scl_fall) begin
            state_d = ST_RD;
            bit_d   = 4'd0;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      shift_q  <= '0;
      first_q  <= '0;
      byte_q   <= 1'b0;
      rw_q     <= 1'b0;
      commit_q <= 1'b0;
      word_q   <= '0;
    end else begin
      state_q  <= state_d;
      bit_q    <= bit_d;
      shift_q  <= shift_d;
      first_q  <= first_d;
      byte_q   <= byte_d;
      rw_q     <= rw_d;
      commit_q <= commit_d;
      word_q   <= word_d;
    end
  end

  assign state_o    = state_q;
  assign sda_hold_n = !(state_q == ST_ADDR_ACK || state_q == ST_WR_ACK);
  assign commit_o   = commit_q;
  assign word_o     = word_q;
endmodule

// File: rtl/dac_code_regs.sv
module dac_code_regs
  import i2c_dac_pkg::*;
#(
  parameter int CHANNELS = NUM_CH
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             commit,
  input  dac_word_t                        word,
  output logic [CHANNELS-1:0][DAC_W-1:0]   codes,
  output logic [CMD_W-1:0]                 cmd_code,
  output logic                             ext_flag
);
  logic             is_ext, ext_d, ext_q;
  logic [CMD_W-1:0] cmd_d, cmd_q;

  assign is_ext = (word.cmd == CMD_EXT) && (word.data[DAC_W-1 -: 4] == 4'h0);

  always_comb begin
    cmd_d = cmd_q;
    ext_d = ext_q;
    if (commit) begin
      cmd_d = word.cmd;
      ext_d = is_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      ext_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      ext_q <= ext_d;
    end
  end

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_ch
    logic             load_en;
    logic [DAC_W-1:0] code_d, code_q;

    assign load_en = commit && !is_ext &&
                     (word.cmd == CMD_W'(ch) || word.cmd == CMD_LOAD_AB);

    always_comb code_d = load_en ? word.data : code_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) code_q <= '0;
      else        code_q <= code_d;
    end

    assign codes[ch] = code_q;
  end

  assign cmd_code = cmd_q;
  assign ext_flag = ext_q;
endmodule

// File: rtl/i2c_dac_slave.sv
module i2c_dac_slave
  import i2c_dac_pkg::*;
#(
  parameter logic [5:0] ADDR_PREFIX = 6'b011100,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             addr_lsb_strap,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             sda_hold_n,
  output logic [DAC_W-1:0] dac_a_code,
  output logic [DAC_W-1:0] dac_b_code,
  output logic [CMD_W-1:0] cmd_code,
  output logic             ext_cmd_flag
);
  logic       rst_sync_n;
  logic       sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic       commit_pulse;
  slv_state_e fsm_state;
  dac_word_t  word;
  logic [NUM_CH-1:0][DAC_W-1:0] codes;

  dac_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  i2c_bus_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_dac_fsm #(.ADDR_PREFIX(ADDR_PREFIX)) u_fsm (
    .clk(clk), .rst_n(rst_sync_n), .addr_lsb(addr_lsb_strap), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .state_o(fsm_state), .sda_hold_n(sda_hold_n),
    .commit_o(commit_pulse), .word_o(word)
  );

  dac_code_regs #(.CHANNELS(NUM_CH)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .commit(commit_pulse), .word(word),
    .codes(codes), .cmd_code(cmd_code), .ext_flag(ext_cmd_flag)
  );

  assign dac_a_code = codes[0];
  assign dac_b_code = codes[1];
endmodule

// File: rtl/i2c_dac_slave_chk.sv
module i2c_dac_slave_chk
  import i2c_dac_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input slv_state_e       state,
  input logic             sda_hold_n,
  input logic             scl_fall,
  input logic             start_det,
  input logic             stop_det,
  input logic             commit,
  input logic [DAC_W-1:0] dac_a_code,
  input logic [DAC_W-1:0] dac_b_code,
  input logic             ext_cmd_flag
);
  assert_drive_after_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_hold_n) |-> $past(scl_fall));

  assert_release_on_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_hold_n) |-> $past(scl_fall || start_det || stop_det));

  assert_dac_moves_after_ack_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_a_code) || !$stable(dac_b_code)) |-> $past(scl_fall, 2));

  assert_ext_keeps_codes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_cmd_flag) |-> ($stable(dac_a_code) && $stable(dac_b_code)));

  assert_idle_until_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && !start_det) |=> state == ST_IDLE);

  assert_commit_from_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(state == ST_WR_ACK));
endmodule

bind i2c_dac_slave i2c_dac_slave_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .state(fsm_state), .sda_hold_n(sda_hold_n),
  .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
  .commit(commit_pulse), .dac_a_code(dac_a_code), .dac_b_code(dac_b_code),
  .ext_cmd_flag(ext_cmd_flag)
);

// File: tb/tb_i2c_dac_slave.sv
`timescale 1ns/1ps
module tb_i2c_dac_slave;
  localparam logic [5:0] PREFIX = 6'b011100;
  localparam logic [5:0] OTHER  = 6'b101100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_hold_n;
  logic [9:0] dac_a, dac_b;
  logic [3:0] cmd;
  logic ext;
  logic sda_bus;
  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & sda_hold_n;

  i2c_dac_slave #(.ADDR_PREFIX(PREFIX)) dut (
    .clk(clk), .rst_n(rst_n), .addr_lsb_strap(strap), .scl_in(scl),
    .sda_in(sda_bus), .sda_hold_n(sda_hold_n), .dac_a_code(dac_a),
    .dac_b_code(dac_b), .cmd_code(cmd), .ext_cmd_flag(ext)
  );

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q();
    repeat (8) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b0; wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q(); scl = 1'b1; wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic bus_bit(input logic b);
    sda_m = b; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0;
  endtask

  task automatic ack_clock(output logic acked);
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    acked = (sda_bus == 1'b0);
    wait_q(); scl = 1'b0; wait_q();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) bus_bit(b[i]);
    ack_clock(acked);
  endtask

  task automatic recv_byte(output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wait_q(); scl = 1'b1; wait_q(); b[i] = sda_bus; wait_q(); scl = 1'b0;
    end
  endtask

  task automatic write_frame(input logic [3:0] c, input logic [9:0] d,
                             input logic [1:0] s, output logic a0,
                             output logic a1, output logic a2);
    bus_start();
    send_byte({PREFIX, strap, 1'b0}, a0);
    send_byte({c, d[9:6]}, a1);
    send_byte({d[5:0], s}, a2);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 dac_a", dac_a, 0);
    chk("R1 dac_b", dac_b, 0);
    chk("R1 cmd", cmd, 0);
    chk("R1 ext", ext, 0);
    chk("R1 sda released", sda_hold_n, 1);
  endtask

  task automatic t_addr();
    logic a;
    strap = 1'b1; wait_q();
    bus_start(); send_byte({PREFIX, 1'b1, 1'b0}, a); bus_stop();
    chk("R2 ack with strap=1", a, 1);
    bus_start(); send_byte({PREFIX, 1'b0, 1'b0}, a); bus_stop();
    chk("R3 nack strap bit mismatch", a, 0);
    strap = 1'b0; wait_q();
    bus_start(); send_byte({OTHER, 1'b0, 1'b0}, a); bus_stop();
    chk("R3 nack other prefix", a, 0);
  endtask

  task automatic t_mismatch_data();
    logic a0, a1, a2;
    bus_start();
    send_byte({OTHER, 1'b0, 1'b0}, a0);
    send_byte(8'h0F, a1);
    send_byte(8'hFC, a2);
    bus_stop();
    chk("R3 addr nack", a0, 0);
    chk("R3 later bytes nack", {a1, a2}, 0);
    chk("R3 dac_a kept", dac_a, 0);
  endtask

  task automatic t_load_channels();
    logic a0, a1, a2;
    write_frame(4'h0, 10'h2A5, 2'b00, a0, a1, a2);
    chk("R4 data bytes acked", {a0, a1, a2}, 3'b111);
    chk("R5 load A", dac_a, 10'h2A5);
    chk("R5 cmd 0", cmd, 0);
    write_frame(4'h1, 10'h15A, 2'b00, a0, a1, a2);
    chk("R5 load B", dac_b, 10'h15A);
    chk("R5 A kept on B load", dac_a, 10'h2A5);
    chk("R5 cmd 1", cmd, 1);
    write_frame(4'h2, 10'h3FF, 2'b00, a0, a1, a2);
    chk("R5 both A", dac_a, 10'h3FF);
    chk("R5 both B", dac_b, 10'h3FF);
  endtask

  task automatic t_timing();
    logic a;
    bus_start();
    send_byte({PREFIX, strap, 1'b0}, a);
    send_byte({4'h0, 4'h0}, a);
    for (int i = 7; i >= 0; i--) bus_bit(i == 7 ? 1'b0 : (i >= 2));
    chk("R6 before ack", dac_a, 10'h3FF);
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q();
    chk("R4 second byte acked", sda_bus, 0);
    wait_q();
    chk("R6 during ack high", dac_a, 10'h3FF);
    scl = 1'b0; wait_q();
    chk("R6 after ack fall", dac_a, 10'h01F);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    bus_start();
    send_byte({PREFIX, strap, 1'b0}, a);
    send_byte({4'h0, 4'hA}, a);
    bus_stop();
    chk("R7 stop after byte one", dac_a, 10'h01F);
    bus_start();
    send_byte({PREFIX, strap, 1'b0}, a);
    send_byte({4'h2, 4'h5}, a);
    for (int i = 0; i < 4; i++) bus_bit(1'b1);
    bus_start();
    send_byte({OTHER, 1'b0, 1'b0}, a);
    bus_stop();
    chk("R7 restart mid byte A", dac_a, 10'h01F);
    chk("R7 restart mid byte B", dac_b, 10'h3FF);
    chk("R7 cmd kept", cmd, 0);
  endtask

  task automatic t_ext();
    logic a0, a1, a2;
    write_frame(4'hF, 10'h03F, 2'b00, a0, a1, a2);
    chk("R8 ext set", ext, 1);
    chk("R8 cmd F", cmd, 4'hF);
    chk("R8 A kept", dac_a, 10'h01F);
    chk("R8 B kept", dac_b, 10'h3FF);
    write_frame(4'hF, 10'h1C0, 2'b00, a0, a1, a2);
    chk("R8 ext cleared", ext, 0);
    chk("R8 no load on F", dac_a, 10'h01F);
    write_frame(4'hF, 10'h000, 2'b00, a0, a1, a2);
    write_frame(4'h1, 10'h123, 2'b00, a0, a1, a2);
    chk("R8 normal word clears", ext, 0);
    chk("R8 normal word loads", dac_b, 10'h123);
  endtask

  task automatic t_subbits();
    logic a0, a1, a2;
    write_frame(4'h0, 10'h001, 2'b01, a0, a1, a2);
    chk("R9 acked", {a0, a1, a2}, 3'b111);
    chk("R9 not committed", dac_a, 10'h01F);
    chk("R9 cmd kept", cmd, 1);
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte({PREFIX, strap, 1'b1}, a);
    chk("R10 read addr acked", a, 1);
    recv_byte(d);
    chk("R11 read data released", d, 8'hFF);
    sda_m = 1'b1; wait_q(); scl = 1'b1; wait_q(); wait_q(); scl = 1'b0; wait_q();
    send_byte(8'h00, a);
    chk("R10 idle after nack", a, 0);
    bus_stop();
  endtask

  task automatic t_stream();
    logic a;
    bus_start();
    send_byte({PREFIX, strap, 1'b0}, a);
    send_byte({4'h0, 4'h4}, a); send_byte(8'h00, a);
    send_byte({4'h1, 4'h0}, a); send_byte({6'h2B, 2'b00}, a);
    bus_stop();
    chk("R12 first word", dac_a, 10'h100);
    chk("R12 second word", dac_b, 10'h02B);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    t_reset();
    t_addr();
    t_mismatch_data();
    t_load_channels();
    t_timing();
    t_abort();
    t_ext();
    t_subbits();
    t_read();
    t_stream();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule